// File: doc/BRIEF.md
# Fixed Priority Core Interrupt Controller

This block merges every interrupt request that reaches a CPU core into one answer: the most urgent request now pending. It has sixteen priority slots. Slot 0 is a reset request and slot 1 a non-maskable interrupt, and neither can be masked. Slots 2 and 3 are held back and are never reported. Slots 4 to 15 take twelve external interrupt lines, and a lower slot number means higher urgency. The winner goes to the CPU as a 4-bit level plus a valid flag, and both come from a register.

External lines are edge-triggered. A rising edge latches a pending bit, which stays set until the CPU acknowledges that level or software clears it through a write-one-to-clear register. Each external level has its own enable bit, and one global enable gates all twelve. A small four-word register port gives software the enables, a view of the pending state, the clear word and the global enable. The reset request is reported for as long as its input stays high. The non-maskable interrupt is latched on its rising edge and only an acknowledge of level 1 clears it.

Top module: `core_irq_ctrl`

## Requirements
- R1: After the asynchronous reset, `irq_valid_o` is 0 and the enable, pending (external and NMI) and global enable state are all zero.
- R2: While `rst_req_i` is high, the next cycle reports level 0. This holds whatever the enables are and whatever else is pending.
- R3: Levels 2 and 3 are never reported. Enable word bits 3:0 always read 0, and writes to those bits have no effect.
- R4: A rising edge of `nmi_i` latches an NMI pending bit. That bit is reported as level 1 whatever the enables are, and it outranks every external level. Only an acknowledge of level 1 clears it.
- R5: Among pending external levels, the lowest number wins. An external level is reported only when its enable bit and the global enable are both 1.
- R6: A rising edge on `ext_irq_i[i]` sets the pending bit of level i+4. If the line stays high after its bit is cleared, the bit is not set again.
- R7: Writing 1s to the clear word (address 2) clears the matching external pending bits (bits 15:4). If a new rising edge arrives on a level in the same cycle, that bit is set.
- R8: An acknowledge (`ack_i` with `ack_level_i`) clears the pending bit of that level. An acknowledge of a level that is not pending, or of level 0, 2 or 3, changes nothing.
- R9: `irq_valid_o`/`irq_level_o` are registered. They show the winner from the request state of the previous cycle, and they are 0 when nothing qualifies.
- R10: Register map by `reg_addr_i`. 0 is the enable word (bit L enables level L, for L 4..15). 1 is pending, read-only: bit 0 is `rst_req_i`, bit 1 is NMI pending, bits 15:4 are external pending, and writes are ignored. 2 is the clear word (write-one, reads 0). 3 is the global enable in bit 0. `reg_rdata_o` is combinational on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_req_i | input | 1 | Reset request (level 0), level sensitive |
| nmi_i | input | 1 | Non-maskable interrupt, rising edge |
| ext_irq_i | input | 12 | External lines, bit i maps to level i+4 |
| ack_i | input | 1 | Acknowledge strobe |
| ack_level_i | input | 4 | Level being acknowledged |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word select |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| irq_valid_o | output | 1 | A level is being reported |
| irq_level_o | output | 4 | Reported priority level |

## Verification
The hardest case to reach is a collision in one cycle: a fresh rising edge arriving on the same level that an acknowledge or a clear-word write is removing. To get there, the line must first be dropped and then raised again in exactly the cycle of the clear. The stimulus creates this collision deliberately in a directed step. A seeded random phase also toggles lines, acknowledges and writes every cycle, so collisions against masking and NMI/reset overlap keep recurring. A cycle-accurate model in the bench checks every output cycle and checks the pending word at intervals.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;
  localparam int unsigned FIXED_LVLS = 4;
  localparam int unsigned LVL_RESET  = 0;
  localparam int unsigned LVL_NMI    = 1;

  typedef enum logic [1:0] {
    REG_ENABLE  = 2'd0,
    REG_PENDING = 2'd1,
    REG_CLEAR   = 2'd2,
    REG_GLOBAL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/core_irq_pend.sv
module core_irq_pend #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] line_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o,
  output logic [WIDTH-1:0] set_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] pend_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign set_o[g] = line_i[g] & ~prev_q[g];
    // a new edge wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[g] <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        prev_q[g] <= line_i[g];
        pend_q[g] <= set_o[g] | (pend_q[g] & ~clr_i[g]);
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/core_irq_regs.sv
module core_irq_regs
  import core_irq_pkg::*;
#(
  parameter  int unsigned NUM_EXT = 12,
  localparam int unsigned NUM_LVL = FIXED_LVLS + NUM_EXT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [NUM_LVL-1:0] wdata_i,
  input  logic [NUM_LVL-1:0] pend_view_i,
  output logic [NUM_EXT-1:0] en_o,
  output logic               gen_o,
  output logic [NUM_EXT-1:0] clr_o,
  output logic [NUM_LVL-1:0] rdata_o
);
  reg_sel_e           sel;
  logic [NUM_EXT-1:0] en_q;
  logic               gen_q;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      gen_q <= 1'b0;
    end else if (we_i) begin
      if (sel == REG_ENABLE) en_q  <= wdata_i[NUM_LVL-1:FIXED_LVLS];
      if (sel == REG_GLOBAL) gen_q <= wdata_i[0];
    end
  end

  assign clr_o = (we_i && sel == REG_CLEAR) ? wdata_i[NUM_LVL-1:FIXED_LVLS] : '0;

  always_comb begin
    unique case (sel)
      REG_ENABLE:  rdata_o = {en_q, {FIXED_LVLS{1'b0}}};
      REG_PENDING: rdata_o = pend_view_i;
      REG_CLEAR:   rdata_o = '0;
      REG_GLOBAL:  rdata_o = {{(NUM_LVL-1){1'b0}}, gen_q};
      default:     rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign gen_o = gen_q;
endmodule

// File: rtl/core_irq_prio.sv
module core_irq_prio #(
  parameter  int unsigned NUM_LVL = 16,
  localparam int unsigned LVL_W   = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] req_i,
  output logic               valid_o,
  output logic [LVL_W-1:0]   level_o
);
  // scan from lowest urgency so the lowest index is written last
  always_comb begin
    valid_o = 1'b0;
    level_o = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        level_o = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/core_irq_ctrl.sv
module core_irq_ctrl
  import core_irq_pkg::*;
#(
  parameter  int unsigned NUM_EXT = 12,
  localparam int unsigned NUM_LVL = FIXED_LVLS + NUM_EXT,
  localparam int unsigned LVL_W   = $clog2(NUM_LVL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rst_req_i,
  input  logic               nmi_i,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic               ack_i,
  input  logic [LVL_W-1:0]   ack_level_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [NUM_LVL-1:0] reg_wdata_i,
  output logic [NUM_LVL-1:0] reg_rdata_o,
  output logic               irq_valid_o,
  output logic [LVL_W-1:0]   irq_level_o
);
  logic [NUM_EXT-1:0] ext_pend, ext_set, ext_ack, ext_clr, reg_clr, en_w;
  logic               gen_w;
  logic               nmi_pend, nmi_set, nmi_clr;
  logic [NUM_LVL-1:0] req_w, pend_view;
  logic               win_valid;
  logic [LVL_W-1:0]   win_level;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ack
    assign ext_ack[g] = ack_i && (ack_level_i == LVL_W'(g + FIXED_LVLS));
  end
  assign nmi_clr = ack_i && (ack_level_i == LVL_W'(LVL_NMI));
  assign ext_clr = ext_ack | reg_clr;

  core_irq_pend #(.WIDTH(NUM_EXT)) u_ext_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (ext_irq_i),
    .clr_i  (ext_clr),
    .pend_o (ext_pend),
    .set_o  (ext_set)
  );

  core_irq_pend #(.WIDTH(1)) u_nmi_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (nmi_i),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend),
    .set_o  (nmi_set)
  );

  assign pend_view = {ext_pend, {(FIXED_LVLS-2){1'b0}}, nmi_pend, rst_req_i};

  core_irq_regs #(.NUM_EXT(NUM_EXT)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .pend_view_i (pend_view),
    .en_o        (en_w),
    .gen_o       (gen_w),
    .clr_o       (reg_clr),
    .rdata_o     (reg_rdata_o)
  );

  // reserved slots are tied off; reset and NMI bypass masking
  assign req_w = {ext_pend & en_w & {NUM_EXT{gen_w}},
                  {(FIXED_LVLS-2){1'b0}}, nmi_pend, rst_req_i};

  core_irq_prio #(.NUM_LVL(NUM_LVL)) u_prio (
    .req_i   (req_w),
    .valid_o (win_valid),
    .level_o (win_level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_valid_o <= 1'b0;
      irq_level_o <= '0;
    end else begin
      irq_valid_o <= win_valid;
      irq_level_o <= win_level;
    end
  end
endmodule

// File: rtl/core_irq_chk.sv
module core_irq_chk
  import core_irq_pkg::*;
#(
  parameter  int unsigned NUM_EXT = 12,
  localparam int unsigned NUM_LVL = FIXED_LVLS + NUM_EXT,
  localparam int unsigned LVL_W   = $clog2(NUM_LVL)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rst_req_i,
  input logic               ack_i,
  input logic [LVL_W-1:0]   ack_level_i,
  input logic               irq_valid_o,
  input logic [LVL_W-1:0]   irq_level_o,
  input logic [NUM_LVL-1:0] req_w,
  input logic [NUM_EXT-1:0] ext_pend,
  input logic [NUM_EXT-1:0] ext_set
);
  localparam logic [LVL_W-1:0] EXT_BASE = LVL_W'(FIXED_LVLS);

  AST_RSVD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (irq_level_o != LVL_W'(2) && irq_level_o != LVL_W'(3))); // R3

  AST_RST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (irq_valid_o && irq_level_o == '0)); // R2

  AST_LVL_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> ((($past(req_w) >> irq_level_o) & NUM_LVL'(1)) != '0)); // R9

  AST_NO_HIGHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (($past(req_w) & ((NUM_LVL'(1) << irq_level_o) - NUM_LVL'(1))) == '0)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_w == '0) |=> !irq_valid_o); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_level_i >= EXT_BASE && !ext_set[ack_level_i - EXT_BASE])
      |=> !ext_pend[$past(ack_level_i) - EXT_BASE]); // R8
endmodule

bind core_irq_ctrl core_irq_chk #(.NUM_EXT(NUM_EXT)) u_chk (.*);

// File: tb/core_irq_ctrl_tb.sv
`timescale 1ns/1ps
module core_irq_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rst_req_i = 1'b0;
  logic        nmi_i = 1'b0;
  logic [11:0] ext_irq_i = '0;
  logic        ack_i = 1'b0;
  logic [3:0]  ack_level_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_valid_o;
  logic [3:0]  irq_level_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model state
  logic [11:0] m_pend = '0, m_prev = '0, m_en = '0;
  logic        m_nmi = 1'b0, m_nmi_prev = 1'b0, m_gen = 1'b0;

  always #4 clk_i = ~clk_i;

  core_irq_ctrl u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] pick(input logic rq, input logic nmi,
                                      input logic [11:0] pend, input logic [11:0] en,
                                      input logic gen);
    logic [11:0] q;
    if (rq) return {1'b1, 4'd0};
    if (nmi) return {1'b1, 4'd1};
    q = pend & en & {12{gen}};
    for (int i = 0; i < 12; i++) if (q[i]) return {1'b1, 4'(i + 4)};
    return 5'd0;
  endfunction

  function automatic logic [15:0] pend_word();
    return {m_pend, 2'b00, m_nmi, rst_req_i};
  endfunction

  // one clock: model next state, then compare registered outputs
  task automatic cycle(input string req);
    logic [4:0]  exp;
    logic [11:0] clr, set;
    logic        nset, nclr;
    exp  = pick(rst_req_i, m_nmi, m_pend, m_en, m_gen);
    set  = ext_irq_i & ~m_prev;
    nset = nmi_i & ~m_nmi_prev;
    clr  = '0;
    nclr = ack_i && ack_level_i == 4'd1;
    if (ack_i && ack_level_i >= 4'd4) clr[ack_level_i - 4'd4] = 1'b1;
    if (reg_we_i && reg_addr_i == 2'd2) clr |= reg_wdata_i[15:4];
    m_pend = set | (m_pend & ~clr);
    m_nmi  = nset | (m_nmi & ~nclr);
    if (reg_we_i && reg_addr_i == 2'd0) m_en = reg_wdata_i[15:4];
    if (reg_we_i && reg_addr_i == 2'd3) m_gen = reg_wdata_i[0];
    m_prev = ext_irq_i;
    m_nmi_prev = nmi_i;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b0;
    ack_i = 1'b0;
    check(irq_valid_o == exp[4] && (!exp[4] || irq_level_o == exp[3:0]), req,
          {irq_valid_o, irq_level_o}, exp);
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string req);
    reg_addr_i = a;
    #1;
    check(reg_rdata_o == exp, req, reg_rdata_o, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
  endtask

  task automatic ack(input logic [3:0] l);
    ack_i = 1'b1; ack_level_i = l;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    check(irq_valid_o == 1'b0, "R1", irq_valid_o, 0);
    rd(2'd0, 16'h0, "R1"); rd(2'd1, 16'h0, "R1"); rd(2'd3, 16'h0, "R1");

    // R3/R10: reserved enable bits ignored
    wr(2'd0, 16'hFFFF); cycle("R10");
    rd(2'd0, 16'hFFF0, "R3");
    wr(2'd3, 16'h0001); cycle("R10");
    rd(2'd3, 16'h0001, "R10");
    rd(2'd2, 16'h0000, "R10");

    // R5 priority between two external levels
    ext_irq_i = 12'h022; cycle("R6");
    cycle("R5");
    check(irq_level_o == 4'd5, "R5", irq_level_o, 5);
    ack(4'd5); cycle("R8");
    cycle("R8");
    check(irq_level_o == 4'd9, "R8", irq_level_o, 9);
    // R6: held line does not re-pend after ack
    ack(4'd9); cycle("R6");
    cycle("R6");
    check(irq_valid_o == 1'b0, "R6", irq_valid_o, 0);
    rd(2'd1, 16'h0000, "R6");

    // R8: ack of idle or reserved levels changes nothing
    ext_irq_i = 12'h000; cycle("R6");
    ext_irq_i = 12'h080; cycle("R6");
    ack(4'd7); cycle("R8");
    ack(4'd2); cycle("R8");
    ack(4'd0); cycle("R8");
    rd(2'd1, 16'h0800, "R8");

    // R5 masking: per-level then global
    wr(2'd0, 16'hF7F0); cycle("R5");
    cycle("R5");
    check(irq_valid_o == 1'b0, "R5", irq_valid_o, 0);
    wr(2'd0, 16'hFFF0); cycle("R5");
    cycle("R5");
    check(irq_level_o == 4'd11, "R5", irq_level_o, 11);
    wr(2'd3, 16'h0000); cycle("R5");
    cycle("R5");
    check(irq_valid_o == 1'b0, "R5", irq_valid_o, 0);

    // R4: NMI ignores global enable; outranks external
    wr(2'd3, 16'h0001); nmi_i = 1'b1; cycle("R4");
    cycle("R4");
    check(irq_level_o == 4'd1, "R4", irq_level_o, 1);
    wr(2'd2, 16'hFFFF); cycle("R4");
    rd(2'd1, 16'h0002, "R4");
    // R2: reset request beats NMI
    rst_req_i = 1'b1; cycle("R2");
    check(irq_level_o == 4'd0, "R2", irq_level_o, 0);
    rd(2'd1, 16'h0003, "R10");
    rst_req_i = 1'b0; cycle("R2");
    cycle("R4");
    check(irq_level_o == 4'd1, "R4", irq_level_o, 1);
    ack(4'd1); cycle("R4");
    nmi_i = 1'b0; cycle("R4");
    check(irq_valid_o == 1'b0, "R4", irq_valid_o, 0);

    // R7: clear word vs simultaneous new edge
    ext_irq_i = 12'h000; cycle("R7");
    ext_irq_i = 12'h003; cycle("R7");
    ext_irq_i = 12'h001; cycle("R7");
    ext_irq_i = 12'h003; wr(2'd2, 16'h0030); cycle("R7");
    rd(2'd1, 16'h0020, "R7");
    wr(2'd1, 16'hFFFF); cycle("R10");
    rd(2'd1, 16'h0020, "R10");
    wr(2'd2, 16'h0020); cycle("R7");
    rd(2'd1, 16'h0000, "R7");

    // random phase
    for (int n = 0; n < 600; n++) begin
      ext_irq_i = 12'($urandom);
      if ($urandom_range(7) == 0) nmi_i = ~nmi_i;
      rst_req_i = ($urandom_range(15) == 0);
      if ($urandom_range(2) == 0) ack($urandom_range(15));
      if ($urandom_range(3) == 0) wr(2'($urandom), 16'($urandom));
      cycle("R9");
      if (n % 16 == 0) rd(2'd1, pend_word(), "R10");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule